// File: doc/BRIEF.md
# Debug Scan Command Decoder

This block sits behind one data register of a boundary-scan port and turns every completed scan into a debug action. An external TAP controller supplies the serial input bit, a shift enable and single-cycle capture and update strobes, all synchronous to the block clock. The block returns the serial output bit. One shift register, sized for the longest frame, collects the bits. The bit shifted in last becomes the top bit of the register, and frames are always read from the top down.

A frame whose top bit is 1 chooses which of four downstream debug units receives later commands: the system bus unit (0), the first CPU (1), the second CPU (2) or the serial console unit (3). A frame whose top bit is 0 is a command for the chosen unit. The 4-bit opcode below the flag can do three things. It can choose an internal register index (0xD). It can write an internal register (0x9). It can announce a burst transfer (0x1 to 0x3 write, 0x5 to 0x7 read). Bursts are only reported upward as a one-cycle strobe with their fields. There is no read opcode. Each Capture loads the currently indexed register into the low end of the shift register, so a following no-operation scan (opcode 0x0) shifts its contents out least significant bit first. Two registers exist: a 2-bit CPU control register and a 33-bit bus error register.

A small state machine tracks the scan. ST_IDLE moves to ST_SCAN on capture or shift, and moves to ST_EXEC on update. ST_SCAN moves to ST_EXEC on update. ST_EXEC always moves on next: to ST_SCAN if capture is asserted, and to ST_IDLE otherwise. All decoded effects are applied in ST_EXEC, one clock after the update strobe.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After reset, the selected unit is 0, both register indices are 0, the control outputs are 0, the error flag is clear, no burst strobe is raised, and the serial output is 0.
- R2: A frame with top bit 1 takes the 2 bits directly below it as the new unit number, presented on `mod_sel`. A frame longer than 3 bits is decoded from its top 3 bits.
- R3: Opcode 0xD stores the 1-bit index found directly below the opcode. The bus unit and the first CPU each keep their own index, and later captures use it.
- R4: Opcode 0x9 with index 0 on the first CPU writes the 2 bits below the index into the control register: bit 0 drives `cpu_stall` and bit 1 drives `cpu_reset`.
- R5: On capture, the indexed register of the selected unit is loaded so that its bit 0 is on `tdo` first. Index 1 and the second CPU read as zero.
- R6: `err_report` sets the error flag (bit 0) and stores `err_addr_in` in bits 32:1. Further reports are ignored while the flag is set.
- R7: Opcode 0x9 with index 0 on the bus unit clears the flag when data bit 0 is 1. A 0 there leaves the register unchanged.
- R8: Opcodes 0x1, 0x2 and 0x3 are burst writes, and 0x5, 0x6 and 0x7 are burst reads. Width codes are 0 for 8-bit, 1 for 16-bit and 2 for 32-bit. The 32-bit address sits directly below the opcode and the 16-bit length fills the lowest bits. `burst_start` is high for exactly the one cycle after the update strobe.
- R9: On either CPU unit, only the 32-bit burst opcodes raise `burst_start`.
- R10: Module commands to unit 3, unknown opcodes, and register writes to index 1 change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| shift_en | input | 1 | Shift the data register one place |
| capture_en | input | 1 | Load the indexed register into the shift path |
| update_en | input | 1 | Frame complete; decode it |
| tdo | output | 1 | Serial data out (bottom bit of the shift path) |
| err_report | input | 1 | Bus master reports a failed access |
| err_addr_in | input | ADDR_W | Address of the failed access |
| mod_sel | output | 2 | Selected debug unit |
| cpu_stall | output | 1 | Control register bit 0 |
| cpu_reset | output | 1 | Control register bit 1 |
| burst_start | output | 1 | One-cycle burst announcement |
| burst_write | output | 1 | Burst direction, 1 means write |
| burst_width | output | 2 | Burst word width code |
| burst_addr | output | ADDR_W | Burst start address |
| burst_len | output | LEN_W | Burst length in words |

## Verification
Frames of every length the block knows are sent: 3-bit unit selects, 6-bit index selects, 8-bit and 39-bit register writes, 5-bit and 33-bit no-operation reads, and 53-bit burst frames. This shows that top alignment places each field correctly whatever the frame length. A 5-bit select frame carrying junk in its low bits separates top alignment from bottom alignment. Bursts on the bus unit and on a CPU unit, with narrow and 32-bit opcodes, separate the width filter from the direction and width decode. Readbacks taken after an index change, after a unit change and after a repeated error report separate the per-unit index storage, the zero readback and the retention of the first error. Writes to unit 3, to index 1 and with an unknown opcode are each followed by a readback or an output check, to show they had no effect.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
    localparam int OPC_W = 4;
    localparam int MOD_W = 2;

    typedef enum logic [MOD_W-1:0] {
        MOD_BUS    = 2'd0,
        MOD_CPU0   = 2'd1,
        MOD_CPU1   = 2'd2,
        MOD_SERIAL = 2'd3
    } mod_e;

    typedef enum logic [1:0] {
        BW_8  = 2'd0,
        BW_16 = 2'd1,
        BW_32 = 2'd2
    } burst_w_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EXEC = 2'd2
    } scan_st_e;

    localparam logic [OPC_W-1:0] OP_NOP     = 4'h0;
    localparam logic [OPC_W-1:0] OP_REG_WR  = 4'h9;
    localparam logic [OPC_W-1:0] OP_IDX_SEL = 4'hD;
endpackage

// File: rtl/dbg_shift_path.sv
module dbg_shift_path #(
    parameter int SR_W = 53,
    parameter int LD_W = 33
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [LD_W-1:0] load_val,
    input  logic            shift,
    input  logic            tdi,
    output logic [SR_W-1:0] frame,
    output logic            tdo
);
    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= {{(SR_W-LD_W){1'b0}}, load_val};
        end else if (shift) begin
            sr_q <= {tdi, sr_q[SR_W-1:1]};
        end
    end

    assign frame = sr_q;
    assign tdo   = sr_q[0];
endmodule

// File: rtl/dbg_frame_decode.sv
module dbg_frame_decode
    import dbg_cmd_pkg::*;
#(
    parameter int SR_W   = 53,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CTRL_W = 2,
    parameter int ERR_W  = 33
) (
    input  logic [SR_W-1:0]   frame,
    input  mod_e              cur_mod,
    output logic              is_sel,
    output mod_e              new_mod,
    output logic              is_idx,
    output logic              is_wr,
    output logic              idx_bit,
    output logic [CTRL_W-1:0] ctrl_data,
    output logic              err_clr_bit,
    output logic              is_burst,
    output logic              burst_wr,
    output burst_w_e          burst_w,
    output logic [ADDR_W-1:0] b_addr,
    output logic [LEN_W-1:0]  b_len
);
    localparam int TOP   = SR_W - 1;
    localparam int OPC_T = TOP - 1;
    localparam int IDX_P = OPC_T - OPC_W;
    localparam int DAT_T = IDX_P - 1;
    localparam int ERR_B = DAT_T - ERR_W + 1;

    logic [OPC_W-1:0] opc;
    logic             mod_cmd;

    always_comb begin
        opc         = frame[OPC_T -: OPC_W];
        new_mod     = mod_e'(frame[OPC_T -: MOD_W]);
        idx_bit     = frame[IDX_P];
        ctrl_data   = frame[DAT_T -: CTRL_W];
        err_clr_bit = frame[ERR_B];
        b_addr      = frame[IDX_P -: ADDR_W];
        b_len       = frame[LEN_W-1:0];
        is_sel      = frame[TOP];
        mod_cmd     = !frame[TOP] && (cur_mod != MOD_SERIAL);
        is_idx      = 1'b0;
        is_wr       = 1'b0;
        is_burst    = 1'b0;
        burst_wr    = 1'b0;
        burst_w     = BW_8;
        if (mod_cmd) begin
            case (opc)
                OP_IDX_SEL: is_idx = 1'b1;
                OP_REG_WR:  is_wr  = 1'b1;
                4'h1, 4'h2, 4'h3, 4'h5, 4'h6, 4'h7: begin
                    burst_wr = !opc[2];
                    burst_w  = burst_w_e'(2'(opc[1:0] - 2'd1));
                    is_burst = (cur_mod == MOD_BUS) || (opc[1:0] == 2'd3);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
    import dbg_cmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 2,
    parameter int ERR_W  = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  mod_e              cur_mod,
    input  logic              is_idx,
    input  logic              is_wr,
    input  logic              idx_bit,
    input  logic [CTRL_W-1:0] ctrl_data,
    input  logic              err_clr_bit,
    input  logic              err_report,
    input  logic [ADDR_W-1:0] err_addr_in,
    output logic [CTRL_W-1:0] cpu_ctrl,
    output logic [ERR_W-1:0]  rd_word
);
    logic              idx_bus_q;
    logic              idx_cpu_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              err_flag_q;
    logic [ADDR_W-1:0] err_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_bus_q  <= 1'b0;
            idx_cpu_q  <= 1'b0;
            ctrl_q     <= '0;
            err_flag_q <= 1'b0;
            err_addr_q <= '0;
        end else begin
            if (exec && is_idx) begin
                if (cur_mod == MOD_BUS)  idx_bus_q <= idx_bit;
                if (cur_mod == MOD_CPU0) idx_cpu_q <= idx_bit;
            end
            if (exec && is_wr && !idx_bit) begin
                if (cur_mod == MOD_BUS && err_clr_bit) err_flag_q <= 1'b0;
                if (cur_mod == MOD_CPU0)               ctrl_q     <= ctrl_data;
            end
            if (err_report && !err_flag_q) begin
                err_flag_q <= 1'b1;
                err_addr_q <= err_addr_in;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (cur_mod == MOD_BUS && !idx_bus_q)
            rd_word = {err_addr_q, err_flag_q};
        else if (cur_mod == MOD_CPU0 && !idx_cpu_q)
            rd_word[CTRL_W-1:0] = ctrl_q;
    end

    assign cpu_ctrl = ctrl_q;
endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
    import dbg_cmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CTRL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic              shift_en,
    input  logic              capture_en,
    input  logic              update_en,
    output logic              tdo,
    input  logic              err_report,
    input  logic [ADDR_W-1:0] err_addr_in,
    output logic [1:0]        mod_sel,
    output logic              cpu_stall,
    output logic              cpu_reset,
    output logic              burst_start,
    output logic              burst_write,
    output logic [1:0]        burst_width,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [LEN_W-1:0]  burst_len
);
    localparam int SR_W  = 1 + OPC_W + ADDR_W + LEN_W;
    localparam int ERR_W = ADDR_W + 1;

    scan_st_e          state_q, state_d;
    mod_e              mod_q;
    logic [SR_W-1:0]   frame;
    logic [ERR_W-1:0]  rd_word;
    logic [CTRL_W-1:0] cpu_ctrl;
    logic              exec;
    logic              is_sel, is_idx, is_wr, idx_bit, err_clr_bit;
    logic              is_burst, b_wr;
    mod_e              new_mod;
    burst_w_e          b_w;
    logic [CTRL_W-1:0] ctrl_data;
    logic [ADDR_W-1:0] b_addr;
    logic [LEN_W-1:0]  b_len;

    // Scan phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (update_en)                    state_d = ST_EXEC;
                else if (capture_en || shift_en)  state_d = ST_SCAN;
            end
            ST_SCAN: if (update_en) state_d = ST_EXEC;
            ST_EXEC: state_d = capture_en ? ST_SCAN : ST_IDLE;
        endcase
    end

    // Outputs of the scan phase
    always_comb begin
        exec        = (state_q == ST_EXEC);
        burst_start = exec && is_burst;
        burst_write = b_wr;
        burst_width = b_w;
        burst_addr  = b_addr;
        burst_len   = b_len;
        cpu_stall   = cpu_ctrl[0];
        cpu_reset   = cpu_ctrl[1];
        mod_sel     = mod_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                mod_q <= MOD_BUS;
        else if (exec && is_sel)   mod_q <= new_mod;
    end

    dbg_shift_path #(.SR_W(SR_W), .LD_W(ERR_W)) u_path (
        .clk(clk), .rst_n(rst_n), .load(capture_en), .load_val(rd_word),
        .shift(shift_en), .tdi(tdi), .frame(frame), .tdo(tdo)
    );

    dbg_frame_decode #(
        .SR_W(SR_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CTRL_W(CTRL_W), .ERR_W(ERR_W)
    ) u_dec (
        .frame(frame), .cur_mod(mod_q), .is_sel(is_sel), .new_mod(new_mod),
        .is_idx(is_idx), .is_wr(is_wr), .idx_bit(idx_bit), .ctrl_data(ctrl_data),
        .err_clr_bit(err_clr_bit), .is_burst(is_burst), .burst_wr(b_wr),
        .burst_w(b_w), .b_addr(b_addr), .b_len(b_len)
    );

    dbg_reg_bank #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .ERR_W(ERR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .exec(exec), .cur_mod(mod_q), .is_idx(is_idx),
        .is_wr(is_wr), .idx_bit(idx_bit), .ctrl_data(ctrl_data),
        .err_clr_bit(err_clr_bit), .err_report(err_report),
        .err_addr_in(err_addr_in), .cpu_ctrl(cpu_ctrl), .rd_word(rd_word)
    );
endmodule

// File: rtl/dbg_cmd_decoder_chk.sv
module dbg_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       update_en,
    input logic [1:0] mod_sel,
    input logic       cpu_stall,
    input logic       cpu_reset,
    input logic       burst_start,
    input logic [1:0] burst_width
);
    // R8: strobe only in the cycle after an update
    p_strobe_after_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> $past(update_en));

    // R8: width code is one of the three defined values
    p_width_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> burst_width != 2'd3);

    // R9: CPU units only announce 32-bit bursts
    p_cpu_word_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_start && mod_sel != 2'd0) |-> burst_width == 2'd2);

    // R2: unit selection moves only two cycles after an update
    p_sel_after_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(update_en, 2) |-> $stable(mod_sel));

    // R4: control outputs move only two cycles after an update
    p_ctrl_after_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(update_en, 2) |-> ($stable(cpu_stall) && $stable(cpu_reset)));
endmodule

bind dbg_cmd_decoder dbg_cmd_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .update_en(update_en), .mod_sel(mod_sel),
    .cpu_stall(cpu_stall), .cpu_reset(cpu_reset), .burst_start(burst_start),
    .burst_width(burst_width)
);

// File: tb/dbg_cmd_decoder_bench.sv
module dbg_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tdi = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
    logic        tdo;
    logic        err_report = 1'b0;
    logic [31:0] err_addr_in = '0;
    logic [1:0]  mod_sel;
    logic        cpu_stall, cpu_reset, burst_start, burst_write;
    logic [1:0]  burst_width;
    logic [31:0] burst_addr;
    logic [15:0] burst_len;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic        s_start, s_wr, s_after;
    logic [1:0]  s_w;
    logic [31:0] s_addr;
    logic [15:0] s_len;
    logic [63:0] got;

    always #4 clk = ~clk;

    dbg_cmd_decoder u_dbg_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .tdi(tdi), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .tdo(tdo),
        .err_report(err_report), .err_addr_in(err_addr_in), .mod_sel(mod_sel),
        .cpu_stall(cpu_stall), .cpu_reset(cpu_reset), .burst_start(burst_start),
        .burst_write(burst_write), .burst_width(burst_width),
        .burst_addr(burst_addr), .burst_len(burst_len)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_scan(input logic [63:0] bits, input int len);
        got = '0;
        capture_en = 1'b1;
        @(posedge clk); @(negedge clk);
        capture_en = 1'b0; shift_en = 1'b1;
        for (int i = 0; i < len; i++) begin
            tdi = bits[i];
            got[i] = tdo;
            @(posedge clk); @(negedge clk);
        end
        shift_en = 1'b0; tdi = 1'b0; update_en = 1'b1;
        @(posedge clk); @(negedge clk);
        update_en = 1'b0;
        s_start = burst_start; s_wr = burst_write; s_w = burst_width;
        s_addr = burst_addr; s_len = burst_len;
        @(posedge clk); @(negedge clk);
        s_after = burst_start;
    endtask

    task automatic sel(input logic [1:0] m);      do_scan({61'b0, 1'b1, m}, 3); endtask
    task automatic idx(input logic i);            do_scan(64'((4'hD << 1) | i), 6); endtask
    task automatic wr_ctrl(input logic i, input logic [1:0] d);
        do_scan(64'(d) | (64'(i) << 2) | (64'h9 << 3), 8);
    endtask
    task automatic wr_err(input logic i, input logic [32:0] d);
        do_scan(64'(d) | (64'(i) << 33) | (64'h9 << 34), 39);
    endtask
    task automatic burst(input logic [3:0] op, input logic [31:0] a, input logic [15:0] n);
        do_scan(64'(n) | (64'(a) << 16) | (64'(op) << 48), 53);
    endtask
    task automatic report(input logic [31:0] a);
        err_addr_in = a; err_report = 1'b1;
        @(posedge clk); @(negedge clk);
        err_report = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 mod_sel", 64'(mod_sel), 0);
        chk("R1 stall/reset", 64'({cpu_reset, cpu_stall}), 0);
        chk("R1 burst_start", 64'(burst_start), 0);
        chk("R1 tdo", 64'(tdo), 0);
        do_scan(64'h0, 33);
        chk("R1 error reg clear", got[32:0], 0);
    endtask

    task automatic t_select;
        sel(2'd2); chk("R2 select 2", 64'(mod_sel), 2);
        sel(2'd3); chk("R2 select 3", 64'(mod_sel), 3);
        do_scan(64'b10111, 5); chk("R2 long frame aligned top", 64'(mod_sel), 1);
    endtask

    task automatic t_ctrl;
        idx(1'b0);
        wr_ctrl(1'b0, 2'b01);
        chk("R4 stall set", 64'({cpu_reset, cpu_stall}), 64'b01);
        wr_ctrl(1'b0, 2'b10);
        chk("R4 reset set", 64'({cpu_reset, cpu_stall}), 64'b10);
        do_scan(64'h0, 5);
        chk("R5 ctrl readback", got[1:0], 64'b10);
    endtask

    task automatic t_index;
        idx(1'b1);
        do_scan(64'h0, 5);
        chk("R3 index 1 reads zero", got[1:0], 0);
        wr_ctrl(1'b1, 2'b01);
        chk("R10 index 1 write ignored", 64'({cpu_reset, cpu_stall}), 64'b10);
        sel(2'd0); sel(2'd1);
        do_scan(64'h0, 5);
        chk("R3 index kept per unit", got[1:0], 0);
        idx(1'b0);
        do_scan(64'h0, 5);
        chk("R3 index 0 restored", got[1:0], 64'b10);
    endtask

    task automatic t_ignored;
        sel(2'd2);
        do_scan(64'h0, 5);
        chk("R5 second CPU reads zero", got[1:0], 0);
        sel(2'd3);
        wr_ctrl(1'b0, 2'b01);
        burst(4'h3, 32'h100, 16'd4);
        chk("R10 serial burst ignored", 64'(s_start), 0);
        sel(2'd1);
        chk("R10 serial write ignored", 64'({cpu_reset, cpu_stall}), 64'b10);
        do_scan(64'h01 | (64'hB << 3), 8);
        chk("R10 unknown opcode no strobe", 64'(s_start), 0);
        chk("R10 unknown opcode no write", 64'({cpu_reset, cpu_stall}), 64'b10);
    endtask

    task automatic t_burst;
        sel(2'd0);
        burst(4'h6, 32'h1234_5678, 16'h00A5);
        chk("R8 read strobe", 64'(s_start), 1);
        chk("R8 read dir", 64'(s_wr), 0);
        chk("R8 16-bit width", 64'(s_w), 1);
        chk("R8 address", 64'(s_addr), 64'h1234_5678);
        chk("R8 length", 64'(s_len), 64'hA5);
        chk("R8 strobe one cycle", 64'(s_after), 0);
        burst(4'h1, 32'hCAFE_0000, 16'd1);
        chk("R8 write strobe", 64'(s_start), 1);
        chk("R8 write dir", 64'(s_wr), 1);
        chk("R8 8-bit width", 64'(s_w), 0);
        sel(2'd1);
        burst(4'h1, 32'h40, 16'd2);
        chk("R9 CPU narrow burst rejected", 64'(s_start), 0);
        burst(4'h7, 32'h80, 16'd3);
        chk("R9 CPU word burst", 64'({s_start, s_wr, s_w}), 64'b1010);
    endtask

    task automatic t_error;
        sel(2'd0); idx(1'b0);
        report(32'hDEAD_BEEF);
        do_scan(64'h0, 33);
        chk("R6 error captured", got[32:0], {32'hDEAD_BEEF, 1'b1});
        report(32'h0000_1111);
        do_scan(64'h0, 33);
        chk("R6 first error kept", got[32:0], {32'hDEAD_BEEF, 1'b1});
        wr_err(1'b0, 33'h0);
        do_scan(64'h0, 33);
        chk("R7 zero write keeps flag", got[32:0], {32'hDEAD_BEEF, 1'b1});
        wr_err(1'b0, 33'h1);
        do_scan(64'h0, 33);
        chk("R7 flag cleared", got[32:0], {32'hDEAD_BEEF, 1'b0});
        report(32'h0000_1111);
        do_scan(64'h0, 33);
        chk("R6 new error after clear", got[32:0], {32'h0000_1111, 1'b1});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_ctrl();
        t_index();
        t_ignored();
        t_burst();
        t_error();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule